// File: doc/BRIEF.md
# Boot Strap Sampler with Delayed Reset Release

This block reads a board-level configuration strap bus exactly once after the peripheral reset goes away. The raw pins first pass through a synchroniser. A cycle counter, started when the input reset deasserts, does two things:

- It releases a delayed reset for downstream logic after a short, fixed number of clock edges.
- At a later fixed edge, it loads the synchronised strap value into a holding register.

Sampling at a fixed offset, rather than continuously, matters because the pins may drift to arbitrary values once the system leaves reset.

After capture, the block raises a valid flag and keeps the word until the next reset. It decodes the word into two outputs:

- an enable for an on-chip bus arbiter;
- a total-memory-size figure in megabytes.

Both decoded outputs read zero until the valid flag is set.

Top module: `boot_strap_sampler`

## Requirements
- R1: While `rst_in_n` is low, `rst_out_n`, `strap_valid`, `arb_en`, `mem_mb` and `strap_word` are all 0, and this applies immediately (asynchronously).
- R2: `rst_out_n` goes high at the 2nd rising clock edge after `rst_in_n` deasserts, and stays high until the next reset.
- R3: At the 5th rising edge after reset release, `strap_word` loads and `strap_valid` rises in the same cycle. The loaded value is the pin value sampled at the 3rd edge, because the pins pass through a two-flop synchroniser.
- R4: Once `strap_valid` is high, changes on `strap_pins` have no effect on `strap_word`, `arb_en` or `mem_mb` until reset is asserted again.
- R5: `arb_en` equals `strap_word` bit 7 while `strap_valid` is high (1 = arbiter enabled, 0 = disabled), and is 0 otherwise.
- R6: `mem_mb` is the 9-bit value 2 shifted left by the code in `strap_word` bits 6:4 while `strap_valid` is high, and is 0 otherwise. Code 000 gives 2 and code 111 gives 256.
- R7: `strap_valid` stays high until `rst_in_n` is asserted. A new reset followed by release repeats the capture with the new pin value.
- R8: A reset asserted before the capture edge aborts the sequence. The count restarts from zero at the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Initial 27 MHz reference clock |
| rst_in_n | input | 1 | Active-low peripheral reset, asynchronous assert |
| strap_pins | input | 8 | Raw configuration strap pins |
| rst_out_n | output | 1 | Delayed active-low reset for downstream logic |
| strap_word | output | 8 | Captured strap word |
| strap_valid | output | 1 | Captured word is held and valid |
| arb_en | output | 1 | Internal bus arbiter enable |
| mem_mb | output | 9 | Decoded memory size in megabytes |

## Verification
A miscounted release counter shows at the ports within five edges of reset release. It appears as `rst_out_n` or `strap_valid` moving one cycle early or late. A synchroniser of the wrong depth shows as a captured word that matches the pins from a neighbouring edge, so the bench drives a different pin value on every edge around the capture point. A capture register that is not locked shows as `strap_word` following the pins one or more cycles after valid rises. The reference model is compared on every clock, so each of these faults is seen in the first cycle it occurs.

// File: rtl/strap_pkg.sv
package strap_pkg;
   function automatic int unsigned cnt_bits(int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage[s] <= '0;
            else if (s == 0)
               stage[s] <= d;
            else
               stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/release_timer.sv
module release_timer
   import strap_pkg::*;
#(
   parameter int unsigned RST_DELAY    = 2,
   parameter int unsigned SAMPLE_DELAY = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_out_n,
   output logic sample_now
);
   localparam int unsigned CW = cnt_bits(SAMPLE_DELAY);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         rst_out_n <= 1'b0;
      end else begin
         if (cnt != CW'(SAMPLE_DELAY))
            cnt <= cnt + 1'b1;
         rst_out_n <= rst_out_n | (cnt >= CW'(RST_DELAY - 1));
      end
   end

   assign sample_now = (cnt == CW'(SAMPLE_DELAY - 1));

   assert_release_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out_n |=> rst_out_n);
   assert_single_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_now |=> !sample_now);
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] word,
   output logic             valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         valid <= 1'b0;
      end else if (load && !valid) begin
         word  <= d;
         valid <= 1'b1;
      end
   end

   assert_valid_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid);
   assert_word_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> $stable(word));
   assert_valid_on_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !valid) |=> valid);
endmodule

// File: rtl/strap_decode.sv
module strap_decode #(
   parameter int unsigned CODE_W  = 3,
   parameter int unsigned SIZE_W  = 9,
   parameter int unsigned BASE_MB = 2
) (
   input  logic              valid,
   input  logic              arb_bit,
   input  logic [CODE_W-1:0] size_code,
   output logic              arb_en,
   output logic [SIZE_W-1:0] mem_mb
);
   always_comb begin
      arb_en = valid & arb_bit;
      mem_mb = valid ? (SIZE_W'(BASE_MB) << size_code) : '0;
   end

   always_comb begin
      if (valid) assert_size_onehot_R6: assert ($countones(mem_mb) == 1);
      if (!valid) assert_arb_gated_R5: assert (!arb_en);
   end
endmodule

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler #(
   parameter int unsigned STRAP_W      = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned RST_DELAY    = 2,
   parameter int unsigned SAMPLE_DELAY = 5,
   parameter int unsigned ARB_BIT      = 7,
   parameter int unsigned SIZE_LSB     = 4,
   parameter int unsigned SIZE_CODE_W  = 3,
   parameter int unsigned SIZE_W       = 9,
   parameter int unsigned BASE_MB      = 2
) (
   input  logic               clk,
   input  logic               rst_in_n,
   input  logic [STRAP_W-1:0] strap_pins,
   output logic               rst_out_n,
   output logic [STRAP_W-1:0] strap_word,
   output logic               strap_valid,
   output logic               arb_en,
   output logic [SIZE_W-1:0]  mem_mb
);
   localparam longint MAX_MB = longint'(BASE_MB) << ((1 << SIZE_CODE_W) - 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (RST_DELAY < 1) begin : g_bad_rst
      $error("RST_DELAY must be at least 1");
   end
   if (SAMPLE_DELAY <= SYNC_STAGES) begin : g_bad_sample
      $error("SAMPLE_DELAY must exceed SYNC_STAGES");
   end
   if (ARB_BIT >= STRAP_W || SIZE_LSB + SIZE_CODE_W > STRAP_W) begin : g_bad_field
      $error("strap field outside the strap word");
   end
   if (MAX_MB >= (longint'(1) << SIZE_W)) begin : g_bad_size
      $error("SIZE_W too narrow for the largest memory size");
   end

   logic [STRAP_W-1:0] pins_sync;
   logic               sample_now;

   strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_in_n), .d(strap_pins), .q(pins_sync));

   release_timer #(.RST_DELAY(RST_DELAY), .SAMPLE_DELAY(SAMPLE_DELAY)) u_timer (
      .clk(clk), .rst_n(rst_in_n), .rst_out_n(rst_out_n), .sample_now(sample_now));

   strap_capture #(.WIDTH(STRAP_W)) u_cap (
      .clk(clk), .rst_n(rst_in_n), .load(sample_now), .d(pins_sync),
      .word(strap_word), .valid(strap_valid));

   strap_decode #(.CODE_W(SIZE_CODE_W), .SIZE_W(SIZE_W), .BASE_MB(BASE_MB)) u_dec (
      .valid(strap_valid), .arb_bit(strap_word[ARB_BIT]),
      .size_code(strap_word[SIZE_LSB +: SIZE_CODE_W]),
      .arb_en(arb_en), .mem_mb(mem_mb));

   assert_valid_after_release_R3: assert property (@(posedge clk) disable iff (!rst_in_n)
      strap_valid |-> rst_out_n);
   assert_first_release_R8: assert property (@(posedge clk) disable iff (!rst_in_n)
      $rose(rst_out_n) |-> !strap_valid);
endmodule

// File: tb/sim_boot_strap_sampler.sv
module sim_boot_strap_sampler;
   localparam int RST_D  = 2;
   localparam int SMP_D  = 5;
   localparam int SYNC_N = 2;

   logic       clk = 1'b0;
   logic       rst_in_n = 1'b0;
   logic [7:0] strap_pins = 8'h00;
   logic       rst_out_n, strap_valid, arb_en;
   logic [7:0] strap_word;
   logic [8:0] mem_mb;

   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   boot_strap_sampler u0 (
      .clk(clk), .rst_in_n(rst_in_n), .strap_pins(strap_pins),
      .rst_out_n(rst_out_n), .strap_word(strap_word), .strap_valid(strap_valid),
      .arb_en(arb_en), .mem_mb(mem_mb));

   int         k = 0;
   logic [7:0] hist[$];
   logic       e_rst = 0, e_valid = 0;
   logic [7:0] e_word = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_in_n) begin
         k = 0; hist.delete();
         e_rst = 0; e_valid = 0; e_word = 0;
      end else begin
         k++;
         hist.push_back(strap_pins);
         if (k >= RST_D) e_rst = 1;
         if (k == SMP_D) begin
            e_word  = hist[SMP_D - SYNC_N - 1];
            e_valid = 1;
         end
      end
      #1;
      if (!rst_in_n) begin
         chk("R1 rst_out_n", rst_out_n, 0);
         chk("R1 valid", strap_valid, 0);
         chk("R1 word", strap_word, 0);
         chk("R1 arb_en", arb_en, 0);
         chk("R1 mem_mb", mem_mb, 0);
      end else begin
         chk(k < 8 ? "R2 rst_out_n" : "R8 rst_out_n", rst_out_n, e_rst);
         chk(k <= SMP_D ? "R3 valid" : "R7 valid", strap_valid, e_valid);
         chk(k <= SMP_D ? "R3 word" : "R4 word", strap_word, e_word);
         chk("R5 arb_en", arb_en, e_valid ? e_word[7] : 0);
         chk("R6 mem_mb", mem_mb, e_valid ? (2 << e_word[6:4]) : 0);
      end
   end

   task automatic run_cycles(int n, bit vary);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (vary) strap_pins = strap_pins * 8'd37 + 8'd11;
      end
   endtask

   task automatic do_reset(int n, logic [7:0] pins);
      @(negedge clk);
      rst_in_n = 0;
      strap_pins = pins;
      #0.5;
      chk("R1 async rst_out_n", rst_out_n, 0);
      chk("R1 async valid", strap_valid, 0);
      run_cycles(n, 0);
      rst_in_n = 1;
   endtask

   initial begin
      strap_pins = 8'hA5;
      run_cycles(4, 0);
      rst_in_n = 1;
      // R3: distinct pin value on every edge around the capture
      run_cycles(10, 1);
      // R4: pins keep changing after capture
      run_cycles(12, 1);
      // R8: abort before capture, then full capture
      do_reset(3, 8'hF0);
      run_cycles(3, 1);
      do_reset(2, 8'h3C);
      run_cycles(12, 1);
      // R6/R5/R7: every size code, both arbiter settings
      for (int c = 0; c < 8; c++) begin
         do_reset(2, {c[0], c[2:0], 4'h9});
         run_cycles(9, 0);
         strap_pins = ~strap_pins;
         run_cycles(3, 0);
      end
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule